// File: doc/BRIEF.md
# Switch-Entry Add/Subtract Calculator

This block is the datapath of a small calculator. Two 8-bit operands come in on switch inputs, and a one-bit mode input picks addition or subtraction. Both operations run through one adder. For subtraction, the second adder input is the bitwise complement of the B operand and the adder's carry-in is forced to 1. The sum is held in a result register. That register changes only when the commit input goes high, so the switches can move freely between commits.

The registered result drives two seven-segment hexadecimal digits, with one digit for each nibble. The block also outputs a signed-overflow flag that is captured together with the result. Reset clears the register, so both digits show 0. Switch debouncing and display multiplexing are handled outside the block.

Top module: `calc_switch_top`

## Requirements
- R1: With sub_mode low, one commit captures (sw_a + sw_b) mod 256 as the displayed result.
- R2: With sub_mode high, one commit captures (sw_a - sw_b) mod 256, computed as sw_a + ~sw_b + 1.
- R3: ovf is captured with the result. It is 1 exactly when the two adder inputs (sw_a, and sw_b or its complement) have the same sign bit and the sum's sign bit differs from it.
- R4: The register updates only in the cycle where commit is first seen high after being low. While commit stays high, later switch changes do not change the outputs.
- R5: While commit is low, the outputs hold their value whatever the switches and sub_mode do.
- R6: Synchronous active-high reset clears the result. Both digits then show 0 and ovf is 0.
- R7: Each digit uses 7 active-high segment bits, bit 0 = a through bit 6 = g. The values 0..F map to 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71.
- R8: hex_segs[6:0] shows result bits [3:0] and hex_segs[13:7] shows result bits [7:4].
- R9: Reset takes priority over a commit in the same cycle. A commit level that is held high through the release of reset produces no update until commit goes low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_a | input | 8 | Operand A switches |
| sw_b | input | 8 | Operand B switches |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| commit | input | 1 | Commit level; a rising level latches the result |
| hex_segs | output | 14 | Two digits of active-high segments, low digit in bits [6:0] |
| ovf | output | 1 | Signed overflow of the latched operation |

## Verification
Reset and a commit edge can land in the same cycle. The bench provokes this by raising reset and commit together while new operands are on the switches. It then keeps commit high while reset is released. Both digits must read 0 throughout, and the outputs must change only after commit has dropped and risen again. Random operands in both modes are compared against sums and overflow flags computed in the bench. Held-commit and idle periods check that the outputs stay fixed while the switches move.

// File: rtl/calc_pkg.sv
package calc_pkg;
  localparam int SEG_W = 7;
  localparam int NIB_W = 4;

  typedef enum logic { OP_ADD = 1'b0, OP_SUB = 1'b1 } op_e;

  function automatic logic [SEG_W-1:0] nib_to_seg(input logic [NIB_W-1:0] n);
    logic [SEG_W-1:0] s;
    case (n)
      4'h0: s = 7'h3F;  4'h1: s = 7'h06;  4'h2: s = 7'h5B;  4'h3: s = 7'h4F;
      4'h4: s = 7'h66;  4'h5: s = 7'h6D;  4'h6: s = 7'h7D;  4'h7: s = 7'h07;
      4'h8: s = 7'h7F;  4'h9: s = 7'h6F;  4'hA: s = 7'h77;  4'hB: s = 7'h7C;
      4'hC: s = 7'h39;  4'hD: s = 7'h5E;  4'hE: s = 7'h79;  default: s = 7'h71;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/calc_addsub.sv
module calc_addsub import calc_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  op_e               op,
  output logic [DATA_W-1:0] sum,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic              cin;
  logic [DATA_W:0]   full;

  // operand mux: B or its complement, carry-in supplies the +1
  always_comb begin
    b_eff = (op == OP_SUB) ? ~opb : opb;
    cin   = (op == OP_SUB);
  end

  assign full = {1'b0, opa} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
  assign sum  = full[MSB:0];
  assign ovf  = (opa[MSB] == b_eff[MSB]) && (sum[MSB] != opa[MSB]);

  always_comb begin
    if (!$isunknown({opa, opb, op})) begin
      if (op == OP_ADD)
        p_add_r1: assert (sum == DATA_W'(opa + opb));
      else
        p_sub_r2: assert (sum == DATA_W'(opa - opb));
      if ((op == OP_ADD) && (opa[MSB] != opb[MSB]))
        p_no_overflow_r3: assert (!ovf);
    end
  end
endmodule

// File: rtl/calc_hex7.sv
module calc_hex7 import calc_pkg::*; (
  input  logic [NIB_W-1:0] nibble,
  output logic [SEG_W-1:0] segs
);
  always_comb segs = nib_to_seg(nibble);
endmodule

// File: rtl/calc_commit_reg.sv
module calc_commit_reg #(
  parameter int PAY_W = 15,
  parameter logic [PAY_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  logic [PAY_W-1:0] d,
  output logic [PAY_W-1:0] q
);
  logic commit_q;
  logic take;

  assign take = commit && !commit_q;

  // commit_q follows commit even in reset so a held level is not a new edge
  always_ff @(posedge clk) begin
    commit_q <= commit;
    if (rst)       q <= RST_VAL;
    else if (take) q <= d;
  end

  p_single_update_r4: assert property (@(posedge clk) disable iff (rst)
    (commit && commit_q) |=> $stable(q));

  p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(q));
endmodule

// File: rtl/calc_switch_top.sv
module calc_switch_top import calc_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [DATA_W-1:0]               sw_a,
  input  logic [DATA_W-1:0]               sw_b,
  input  logic                            sub_mode,
  input  logic                            commit,
  output logic [(DATA_W/NIB_W)*SEG_W-1:0] hex_segs,
  output logic                            ovf
);
  localparam int DIGITS = DATA_W / NIB_W;
  localparam int DISP_W = DIGITS * SEG_W;
  localparam int PAY_W  = DISP_W + 1;
  localparam logic [DISP_W-1:0] ZERO_DISP = {DIGITS{7'h3F}};

  op_e               op;
  logic [DATA_W-1:0] sum;
  logic              sum_ovf;
  logic [DISP_W-1:0] next_segs;
  logic [PAY_W-1:0]  pay_q;

  assign op = sub_mode ? OP_SUB : OP_ADD;

  calc_addsub #(.DATA_W(DATA_W)) u_addsub (
    .opa(sw_a), .opb(sw_b), .op(op), .sum(sum), .ovf(sum_ovf)
  );

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    calc_hex7 u_dig (
      .nibble(sum[d*NIB_W +: NIB_W]),
      .segs  (next_segs[d*SEG_W +: SEG_W])
    );
  end

  calc_commit_reg #(.PAY_W(PAY_W), .RST_VAL({1'b0, ZERO_DISP})) u_reg (
    .clk(clk), .rst(rst), .commit(commit),
    .d({sum_ovf, next_segs}), .q(pay_q)
  );

  assign hex_segs = pay_q[DISP_W-1:0];
  assign ovf      = pay_q[DISP_W];

  p_reset_clear_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (hex_segs == ZERO_DISP) && !ovf);
endmodule

// File: tb/tb_calc_switch_top.sv
module tb_calc_switch_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sw_a = '0, sw_b = '0;
  logic       sub_mode = 1'b0, commit = 1'b0;
  logic [13:0] hex_segs;
  logic       ovf;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  calc_switch_top dut (.clk(clk), .rst(rst), .sw_a(sw_a), .sw_b(sw_b),
    .sub_mode(sub_mode), .commit(commit), .hex_segs(hex_segs), .ovf(ovf));

  function automatic logic [6:0] seg_of(input logic [3:0] v);
    case (v)
      0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
      4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
      8: return 7'h7F;  9: return 7'h6F;  10: return 7'h77; 11: return 7'h7C;
      12: return 7'h39; 13: return 7'h5E; 14: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  // expected {ovf, hi digit, lo digit}
  function automatic logic [14:0] expect_out(input logic [7:0] a, b, input logic s);
    int sa, sb, r;
    logic [7:0] res;
    sa  = $signed(a);
    sb  = $signed(b);
    r   = s ? sa - sb : sa + sb;
    res = s ? a - b : a + b;
    return {(r > 127 || r < -128), seg_of(res[7:4]), seg_of(res[3:0])};
  endfunction

  task automatic check(input string req, input logic [14:0] exp);
    n_chk++;
    if ({ovf, hex_segs} !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, {ovf, hex_segs}, exp);
    end
  endtask

  task automatic do_commit(input logic [7:0] a, b, input logic s, input string req);
    @(negedge clk); sw_a = a; sw_b = b; sub_mode = s; commit = 1'b1;
    @(negedge clk); check(req, expect_out(a, b, s));
    commit = 1'b0;
    @(negedge clk);
  endtask

  localparam logic [14:0] ZERO = {1'b0, 7'h3F, 7'h3F};

  initial begin
    repeat (3000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [14:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R6 reset display", ZERO);
    rst = 1'b0;
    @(negedge clk);
    check("R6 after release", ZERO);

    do_commit(8'h12, 8'h25, 1'b0, "R1 add");
    do_commit(8'hFF, 8'h01, 1'b0, "R1 wrap");
    do_commit(8'h25, 8'h12, 1'b1, "R2 sub");
    do_commit(8'h00, 8'h01, 1'b1, "R2 borrow");
    do_commit(8'h7F, 8'h01, 1'b0, "R3 add ovf");
    do_commit(8'h80, 8'h01, 1'b1, "R3 sub ovf");
    do_commit(8'h80, 8'h80, 1'b1, "R3 sub no ovf");
    do_commit(8'h80, 8'h7F, 1'b0, "R3 opposite signs");
    for (int v = 0; v < 16; v++)
      do_commit(8'((v << 4) | (15 - v)), 8'h00, 1'b0, "R7 R8 digit map");

    // R4: held commit ignores later switch changes
    @(negedge clk); sw_a = 8'h3C; sw_b = 8'h04; sub_mode = 1'b0; commit = 1'b1;
    @(negedge clk); held = expect_out(8'h3C, 8'h04, 1'b0);
    check("R4 first edge", held);
    sw_a = 8'h99; sw_b = 8'h11; sub_mode = 1'b1;
    repeat (4) @(negedge clk);
    check("R4 held level", held);
    commit = 1'b0;

    // R5: idle commit ignores switches
    repeat (2) @(negedge clk); sw_a = 8'h01; sw_b = 8'h02; sub_mode = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 idle", held);

    // R9: reset and commit edge together, commit held through release
    @(negedge clk); rst = 1'b1; commit = 1'b1; sw_a = 8'hAB; sw_b = 8'h11;
    @(negedge clk); check("R9 reset wins", ZERO);
    rst = 1'b0;
    repeat (3) @(negedge clk); check("R9 held through release", ZERO);
    commit = 1'b0;
    @(negedge clk);
    do_commit(8'hAB, 8'h11, 1'b0, "R9 next edge");

    for (int i = 0; i < 200; i++) begin
      logic [7:0] ra, rb;
      logic rs;
      ra = 8'($urandom); rb = 8'($urandom); rs = 1'($urandom);
      do_commit(ra, rb, rs, rs ? "R2 R3 random" : "R1 R3 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule